// File: doc/BRIEF.md
# SD Card Clock Divider

This block generates the clock for an SD card bus from the system clock. A single control word, loaded through a write strobe, holds four things: a 7-bit divisor, a run flag, a stop flag and a high-speed select. While running, the card clock toggles after every `div+1` system cycles. The resulting frequency is sysclk/(2·(div+1)). That gives sysclk/2 at a divisor of 0 and sysclk/256 at a divisor of 127.

Alongside the card clock, the block produces two one-cycle pulses for the command and data logic that shares the system clock:
- a rising-edge enable, asserted in the first system cycle of each high phase;
- a falling-edge enable, asserted in the first system cycle of each low phase.

A third pulse marks the output launch point. It follows the falling-edge enable in normal mode and the rising-edge enable in high-speed mode.

Divisor changes and stops are glitch-free:
- A new divisor is adopted only where one output period ends and the next begins, at the falling transition.
- A stop that arrives during a high phase lets that phase finish before the clock parks low.

After reset the clock is stopped and the divisor holds its slowest value.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the card clock is low and the rising, falling and launch enables are all deasserted until the control word is written.
- R2: The control word places the divisor in bits 6:0, the run flag in bit 7, the stop flag in bit 8 and the high-speed select in bit 9. While running with divisor d, each high phase and each low phase lasts exactly d+1 system cycles, giving a period of 2·(d+1).
- R3: With divisor 0 the card clock toggles on every system cycle, giving one system cycle high and one low.
- R4: With divisor 127 each phase lasts 128 system cycles, giving a period of 256.
- R5: The rising enable is high in exactly the first system cycle in which the card clock is high, and the falling enable is high in exactly the first cycle in which it is low. The two are never high together, and the card clock never changes without the matching enable.
- R6: The clock runs only when the run flag (bit 7) is 1 and the stop flag (bit 8) is 0. With the stop flag set, the card clock stays low whatever the run flag holds.
- R7: A stop requested during a high phase lets that phase complete its full d+1 cycles, ends it with one falling edge, and then holds the card clock low with no further enables.
- R8: A divisor written while the clock runs takes effect at the next falling transition of the card clock. Every period keeps equal high and low lengths, and the period in progress when the write lands keeps the old divisor.
- R9: The launch enable equals the falling enable when the high-speed select (bit 9) is 0, and the rising enable when it is 1.
- R10: Starting a stopped clock with divisor d produces the first rising enable d+2 cycles after the cycle in which the write is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Control-word write strobe |
| cfg_wdata_i | input | 10 | Control word: hs[9], stop[8], run[7], divisor[6:0] |
| sd_clk_o | output | 1 | Card clock |
| rise_en_o | output | 1 | One-cycle pulse in the first high cycle of the card clock |
| fall_en_o | output | 1 | One-cycle pulse in the first low cycle of the card clock |
| launch_en_o | output | 1 | Output launch pulse, chosen by the high-speed select |

## Verification
The divider is driven with the extreme divisors 0 and 127, a mid value, and a seeded random series of divisors written at random points inside a running period. The fixed divisors pin down the exact phase length. The random mid-period writes separate a period that keeps its old divisor from one that adopts the new one, and they expose any period whose high and low phases differ. Stops are issued both in the low phase and partway through a high phase, to tell a clean park from a truncated pulse. The high-speed select is toggled while running to show that the launch pulse moves from one edge enable to the other.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    localparam int unsigned SDC_DIV_W   = 7;
    localparam int unsigned SDC_CFG_W   = SDC_DIV_W + 3;
    localparam int unsigned SDC_DIV_MAX = (1 << SDC_DIV_W) - 1;

    // Control word; field order fixes the bit positions seen at the write port.
    typedef struct packed {
        logic                 hs;
        logic                 stop;
        logic                 run;
        logic [SDC_DIV_W-1:0] div;
    } sdc_cfg_t;

    // State of the phase generator.
    typedef struct packed {
        logic                 live;
        logic                 sd;
        logic                 rise;
        logic                 fall;
        logic [SDC_DIV_W-1:0] cnt;
        logic [SDC_DIV_W-1:0] div_act;
    } sdc_phase_t;

endpackage

// File: rtl/sdc_cfg_reg.sv
module sdc_cfg_reg
    import sdclk_pkg::*;
#(
    parameter int unsigned DIV_RST = SDC_DIV_MAX
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     we_i,
    input  sdc_cfg_t wdata_i,
    output sdc_cfg_t cfg_o,
    output logic     run_o
);

    localparam logic [SDC_DIV_W-1:0] RST_DIV = SDC_DIV_W'(DIV_RST);

    sdc_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            cfg_d = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q.hs   <= 1'b0;
            cfg_q.stop <= 1'b1;
            cfg_q.run  <= 1'b0;
            cfg_q.div  <= RST_DIV;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;
    // The stop flag overrides the run flag.
    assign run_o = cfg_q.run && !cfg_q.stop;

endmodule

// File: rtl/sdc_phase_gen.sv
module sdc_phase_gen
    import sdclk_pkg::*;
#(
    parameter int unsigned DIV_RST = SDC_DIV_MAX
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 run_i,
    input  logic [SDC_DIV_W-1:0] div_i,
    output logic                 sd_clk_o,
    output logic                 rise_o,
    output logic                 fall_o,
    output logic                 live_o,
    output logic [SDC_DIV_W-1:0] div_act_o
);

    localparam logic [SDC_DIV_W-1:0] RST_DIV = SDC_DIV_W'(DIV_RST);

    sdc_phase_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (!st_q.live) begin
            // Parked: low, counter cleared, divisor tracks the register.
            st_d.sd      = 1'b0;
            st_d.cnt     = '0;
            st_d.div_act = div_i;
            st_d.live    = run_i;
        end else if (!st_q.sd && !run_i) begin
            // Stop in the low phase: park at once, no pulse is shortened.
            st_d.live    = 1'b0;
            st_d.cnt     = '0;
            st_d.div_act = div_i;
        end else if (st_q.cnt == st_q.div_act) begin
            st_d.cnt = '0;
            st_d.sd  = !st_q.sd;
            if (st_q.sd) begin
                // Period boundary: adopt the pending divisor.
                st_d.fall    = 1'b1;
                st_d.div_act = div_i;
            end else begin
                st_d.rise = 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.live    <= 1'b0;
            st_q.sd      <= 1'b0;
            st_q.rise    <= 1'b0;
            st_q.fall    <= 1'b0;
            st_q.cnt     <= '0;
            st_q.div_act <= RST_DIV;
        end else begin
            st_q <= st_d;
        end
    end

    assign sd_clk_o  = st_q.sd;
    assign rise_o    = st_q.rise;
    assign fall_o    = st_q.fall;
    assign live_o    = st_q.live;
    assign div_act_o = st_q.div_act;

endmodule

// File: rtl/sdc_launch_sel.sv
module sdc_launch_sel (
    input  logic hs_i,
    input  logic rise_i,
    input  logic fall_i,
    output logic launch_o
);

    always_comb begin
        launch_o = hs_i ? rise_i : fall_i;
    end

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int unsigned DIV_RST = SDC_DIV_MAX
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 cfg_we_i,
    input  logic [SDC_CFG_W-1:0] cfg_wdata_i,
    output logic                 sd_clk_o,
    output logic                 rise_en_o,
    output logic                 fall_en_o,
    output logic                 launch_en_o
);

    sdc_cfg_t             cfg_w;
    logic                 run_w;
    logic                 live_w;
    logic [SDC_DIV_W-1:0] div_act_w;

    sdc_cfg_reg #(
        .DIV_RST (DIV_RST)
    ) i_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .wdata_i (sdc_cfg_t'(cfg_wdata_i)),
        .cfg_o   (cfg_w),
        .run_o   (run_w)
    );

    sdc_phase_gen #(
        .DIV_RST (DIV_RST)
    ) i_phase (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run_w),
        .div_i     (cfg_w.div),
        .sd_clk_o  (sd_clk_o),
        .rise_o    (rise_en_o),
        .fall_o    (fall_en_o),
        .live_o    (live_w),
        .div_act_o (div_act_w)
    );

    sdc_launch_sel i_launch (
        .hs_i     (cfg_w.hs),
        .rise_i   (rise_en_o),
        .fall_i   (fall_en_o),
        .launch_o (launch_en_o)
    );

endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk
    import sdclk_pkg::*;
(
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 run,
    input logic                 live,
    input logic [SDC_DIV_W-1:0] div_act,
    input logic                 sd_clk,
    input logic                 rise_en,
    input logic                 fall_en,
    input logic                 launch_en
);

    a_r5_rise_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_en |-> (sd_clk && !$past(sd_clk)));

    a_r5_fall_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_en |-> (!sd_clk && $past(sd_clk)));

    a_r5_no_silent_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sd_clk) |-> rise_en);

    a_r5_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rise_en && fall_en));

    a_r7_park_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && !sd_clk) |=> (!sd_clk && !rise_en));

    a_r8_div_load_point: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(div_act) |-> (fall_en || !live || !$past(live)));

    a_r9_launch_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        launch_en |-> (rise_en || fall_en));

endmodule

bind sdclk_gen sdclk_gen_chk i_sdclk_gen_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run       (run_w),
    .live      (live_w),
    .div_act   (div_act_w),
    .sd_clk    (sd_clk_o),
    .rise_en   (rise_en_o),
    .fall_en   (fall_en_o),
    .launch_en (launch_en_o)
);

// File: tb/test_sdclk_gen.sv
module test_sdclk_gen;
    import sdclk_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 we = 1'b0;
    logic [SDC_CFG_W-1:0] wdata = '0;
    logic                 sd_clk, rise_en, fall_en, launch_en;

    int  n_chk = 0;
    int  n_err = 0;
    int  cyc = 0;
    int  mon_err = 0;
    bit  done = 1'b0;
    bit  hs_m = 1'b0;
    bit  prev_sd = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdclk_gen i_sdclk_gen (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_we_i    (we),
        .cfg_wdata_i (wdata),
        .sd_clk_o    (sd_clk),
        .rise_en_o   (rise_en),
        .fall_en_o   (fall_en),
        .launch_en_o (launch_en)
    );

    function automatic logic [SDC_CFG_W-1:0] pack_cfg(int div, bit run, bit stop, bit hs);
        return {hs, stop, run, SDC_DIV_W'(div)};
    endfunction

    function automatic int half_len(int div);
        return div + 1;
    endfunction

    function automatic int start_lat(int div);
        return div + 2;
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Caller stands at a negedge; the write is registered at the next posedge.
    task automatic cfg_write(int div, bit run, bit stop, bit hs);
        we    = 1'b1;
        wdata = pack_cfg(div, run, stop, hs);
        @(posedge clk);
        hs_m = hs;
        @(negedge clk);
        we = 1'b0;
    endtask

    // Measures one period that starts at a falling enable.
    task automatic wait_period(output int lo, output int hi);
        while (!fall_en) @(negedge clk);
        lo = 0;
        while (!rise_en) begin lo++; @(negedge clk); end
        hi = 0;
        while (!fall_en) begin hi++; @(negedge clk); end
    endtask

    task automatic count_activity(int n, output int act);
        act = 0;
        repeat (n) begin
            @(negedge clk);
            if (sd_clk || rise_en || fall_en || launch_en) act++;
        end
    endtask

    // Per-cycle edge and launch monitor (R5, R9).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rise_en !== (sd_clk && !prev_sd)) mon_err++;
            if (fall_en !== (!sd_clk && prev_sd)) mon_err++;
            if (launch_en !== (hs_m ? rise_en : fall_en)) mon_err++;
        end
        prev_sd <= sd_clk;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_CYC && !done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG_CYC);
            finish_run();
        end
    end

    initial begin
        int lo, hi, n, act;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet after reset.
        count_activity(60, act);
        check(act == 0, "R1 reset quiet", act, 0);

        // R10: start latency, R2: phase lengths with divisor 3.
        cfg_write(3, 1, 0, 0);
        n = 0;
        while (!rise_en) begin @(negedge clk); n++; end
        check(n == start_lat(3), "R10 start latency", n, start_lat(3));
        for (int i = 0; i < 3; i++) begin
            wait_period(lo, hi);
            check(lo == half_len(3), "R2 low phase", lo, half_len(3));
            check(hi == half_len(3), "R2 high phase", hi, half_len(3));
        end

        // R3: divisor 0.
        cfg_write(0, 1, 0, 0);
        wait_period(lo, hi);
        wait_period(lo, hi);
        check(lo == 1 && hi == 1, "R3 div0 low", lo, 1);
        check(hi == 1, "R3 div0 high", hi, 1);

        // R4: divisor 127.
        cfg_write(127, 1, 0, 0);
        wait_period(lo, hi);
        wait_period(lo, hi);
        check(lo + hi == 256, "R4 div127 period", lo + hi, 256);

        // R8: write at the start of a period; that period keeps the old divisor.
        cfg_write(5, 1, 0, 0);
        wait_period(lo, hi);
        fork
            cfg_write(2, 1, 0, 0);
            wait_period(lo, hi);
        join
        check(lo == half_len(5) && hi == half_len(5), "R8 old period kept", lo + hi, 2*half_len(5));
        wait_period(lo, hi);
        check(lo == half_len(2) && hi == half_len(2), "R8 new period", lo + hi, 2*half_len(2));

        // R9: high-speed launch on the rising enable.
        cfg_write(4, 1, 0, 1);
        while (!rise_en) @(negedge clk);
        check(launch_en == 1'b1, "R9 hs launch at rise", launch_en, 1);
        while (!fall_en) @(negedge clk);
        check(launch_en == 1'b0, "R9 hs no launch at fall", launch_en, 0);
        cfg_write(4, 1, 0, 0);
        while (!fall_en) @(negedge clk);
        check(launch_en == 1'b1, "R9 normal launch at fall", launch_en, 1);

        // R6: stop flag wins over the run flag.
        cfg_write(4, 1, 1, 0);
        repeat (12) @(negedge clk);
        count_activity(300, act);
        check(act == 0, "R6 stop overrides run", act, 0);
        cfg_write(4, 0, 0, 0);
        count_activity(100, act);
        check(act == 0, "R6 run flag clear", act, 0);

        // R7: stop during a high phase completes it.
        cfg_write(9, 1, 0, 0);
        while (!rise_en) @(negedge clk);
        fork
            cfg_write(9, 0, 0, 0);
            begin
                hi = 0;
                while (!fall_en) begin hi++; @(negedge clk); end
            end
        join
        check(hi == half_len(9), "R7 high phase completed", hi, half_len(9));
        count_activity(200, act);
        check(act == 0, "R7 parked low", act, 0);

        // R8, R2: random divisors written at random points of a running clock.
        cfg_write(6, 1, 0, 0);
        for (int i = 0; i < 24; i++) begin
            int old_div, new_div;
            bit hs;
            old_div = (i == 0) ? 6 : old_div;
            new_div = ($urandom % 4 == 0) ? int'($urandom % 128) : int'($urandom % 12);
            hs      = 1'($urandom % 2);
            repeat ($urandom % (2*old_div + 2)) @(negedge clk);
            cfg_write(new_div, 1, 0, hs);
            wait_period(lo, hi);
            check(lo == hi && (lo == half_len(old_div) || lo == half_len(new_div)),
                  "R8 symmetric transition period", lo, half_len(new_div));
            wait_period(lo, hi);
            check(lo == half_len(new_div) && hi == half_len(new_div),
                  "R2 random settled period", lo + hi, 2*half_len(new_div));
            old_div = new_div;
        end

        check(mon_err == 0, "R5 R9 edge monitor", mon_err, 0);
        finish_run();
    end

endmodule